// File: doc/BRIEF.md
# PWM Compare Output Channel

This block is one compare channel of a general-purpose timer, together with the counter that drives it. The counter either counts up and wraps from the reload value to zero (edge-aligned), or runs up to the reload value and back down to zero (center-aligned). Each cycle, a compare unit tests the counter against the active compare value. From that result and a 3-bit output mode it produces a reference waveform. The modes are a forced low level, a forced high level and two PWM modes that are the inverse of each other.

The compare value and the reload value each sit behind a preload register. When preloading is enabled, a written value reaches the working (shadow) copy only on an update event. Update events come from the counter turning around or from a software update strobe. The update strobe also restarts the counter, so software normally writes both values and then pulses it before letting the PWM run.

A sticky compare flag records matches. It keeps working while the output is forced. In center-aligned operation the alignment mode selects whether matches count while the counter moves down, while it moves up, or in both directions. An interrupt request follows the flag, gated by an enable input.

Top module: `pwm_cmp_channel`

## Requirements
- R1: With `out_mode` = 3'b100 `ocref` is 0 regardless of counter and compare value; any code with bit 2 clear also gives 0.
- R2: With `out_mode` = 3'b101 `ocref` is 1 regardless of counter and compare value.
- R3: With `out_mode` = 3'b110 `ocref` is 1 exactly when `cnt_val` is greater than the active compare value. With 3'b111 it is the inverse of that level.
- R4: While `cnt_en` is 1 and the counter equals the active compare value, `cmp_flag` reads 1 in the next cycle. This holds in every output mode, forced ones included.
- R5: `cmp_flag` stays set until `flag_clr` is pulsed. A set in the same cycle as `flag_clr` wins. `irq` equals `cmp_flag` AND `irq_en`.
- R6: With `align_mode` = 2'b00 the counter steps 0,1,..,reload and then returns to 0. `upd_evt` is 1 in the cycle after each wrap, and `cnt_dir` stays 0.
- R7: With `align_mode` other than 2'b00 the counter runs 0 up to reload and back down to 0, with a period of twice the reload value. `cnt_dir` is 1 while counting down, including at the bottom value 0. `upd_evt` is 1 in the cycle after each of the two turnarounds.
- R8: In center-aligned operation a match sets the flag only while counting down for 2'b01, only while counting up for 2'b10, and in both directions for 2'b11.
- R9: With `cmp_pre_en` = 1 a compare write changes the active compare value only at the next update event. With `cmp_pre_en` = 0 it takes effect in the next cycle.
- R10: With `rld_pre_en` = 1 a reload write changes the active reload value only at the next update event. With `rld_pre_en` = 0 it takes effect in the next cycle.
- R11: An `upd_gen` pulse sets the counter to 0 counting up, loads both preload values into the active copies, and makes `upd_evt` 1 in the next cycle.
- R12: While `cnt_en` is 0 (and no `upd_gen`) the counter holds its value and no match sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter run enable |
| align_mode | input | 2 | 00 edge, 01 center flag-down, 10 center flag-up, 11 center both |
| out_mode | input | 3 | 100 low, 101 high, 110 PWM A, 111 PWM B |
| rld_pre_en | input | 1 | Buffer reload writes until an update event |
| rld_wr | input | 1 | Reload write strobe |
| rld_wdata | input | W | Reload write value |
| cmp_pre_en | input | 1 | Buffer compare writes until an update event |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | W | Compare write value |
| upd_gen | input | 1 | Software update strobe |
| flag_clr | input | 1 | Clears the compare flag |
| irq_en | input | 1 | Interrupt enable |
| cnt_val | output | W | Counter value |
| cnt_dir | output | 1 | 1 while counting down |
| upd_evt | output | 1 | Pulse one cycle after an update event |
| ocref | output | 1 | Reference output level |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the dependence of the flag on counting direction in the three center-aligned modes. The compare value is visited twice per period, once on each slope, and only the alignment mode decides which visit counts. The bench holds `flag_clr` high through whole center-aligned periods, which reduces the flag to a one-cycle delayed image of each qualified match. Every cycle can then be compared against a direction computed from the counter's position in its period. A second hard case is a compare or reload write that lands mid-period with preloading on. The write is placed a few cycles after an update strobe, and the output is sampled on both sides of the next wrap.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;

    typedef enum logic [1:0] {
        AL_EDGE     = 2'b00,
        AL_CTR_DN   = 2'b01,
        AL_CTR_UP   = 2'b10,
        AL_CTR_BOTH = 2'b11
    } align_e;

    localparam logic [2:0] OM_LOW   = 3'b100;
    localparam logic [2:0] OM_HIGH  = 3'b101;
    localparam logic [2:0] OM_PWM_A = 3'b110;
    localparam logic [2:0] OM_PWM_B = 3'b111;

endpackage

// File: rtl/pwm_ch_counter.sv
module pwm_ch_counter
    import pwm_ch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         upd_gen,
    input  logic [1:0]   align,
    input  logic [W-1:0] rld_sh,
    output logic [W-1:0] cnt,
    output logic         down,
    output logic         upd_now,
    output logic         upd_evt
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
        logic         upd;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    turn;

    always_comb begin
        st_d     = st_q;
        turn     = 1'b0;
        if (upd_gen) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (cnt_en) begin
            if (align_e'(align) == AL_EDGE) begin
                st_d.down = 1'b0;
                if (st_q.cnt >= rld_sh) begin
                    st_d.cnt = '0;
                    turn     = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (rld_sh == '0) begin
                st_d.cnt  = '0;
                st_d.down = 1'b0;
                turn      = 1'b1;
            end else if (!st_q.down) begin
                if (st_q.cnt >= rld_sh) begin
                    st_d.cnt  = rld_sh - 1'b1;
                    st_d.down = 1'b1;
                    turn      = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.cnt  = {{(W-1){1'b0}}, 1'b1};
                    st_d.down = 1'b0;
                    turn      = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
        st_d.upd = upd_gen | turn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign down    = st_q.down;
    assign upd_evt = st_q.upd;
    assign upd_now = st_d.upd;

endmodule

// File: rtl/pwm_ch_preload.sv
module pwm_ch_preload #(
    parameter int           W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pre_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         upd_now,
    output logic [W-1:0] active
);

    typedef struct packed {
        logic [W-1:0] pre;
        logic [W-1:0] sh;
    } pl_st_t;

    pl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.pre = wdata;
        end
        if (wr && !pre_en) begin
            st_d.sh = wdata;
        end else if (upd_now) begin
            st_d.sh = st_q.pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pre: INIT, sh: INIT};
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.sh;

endmodule

// File: rtl/pwm_ch_compare.sv
module pwm_ch_compare
    import pwm_ch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic [W-1:0] cnt,
    input  logic         down,
    input  logic [W-1:0] ccr_sh,
    input  logic [1:0]   align,
    input  logic [2:0]   out_mode,
    input  logic         flag_clr,
    input  logic         irq_en,
    output logic         ocref,
    output logic         flag,
    output logic         irq
);

    typedef struct packed {
        logic flag;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic    match;
    logic    qual;
    logic    above;

    always_comb begin
        match = cnt_en && (cnt == ccr_sh);
        unique case (align_e'(align))
            AL_CTR_DN: qual = down;
            AL_CTR_UP: qual = !down;
            default:   qual = 1'b1;
        endcase
        st_d.flag = (match && qual) || (st_q.flag && !flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        above = cnt > ccr_sh;
        unique case (out_mode)
            OM_HIGH:  ocref = 1'b1;
            OM_PWM_A: ocref = above;
            OM_PWM_B: ocref = !above;
            default:  ocref = 1'b0;
        endcase
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & irq_en;

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel #(
    parameter int           W        = 8,
    parameter logic [W-1:0] RLD_INIT = '1,
    parameter logic [W-1:0] CMP_INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic [1:0]   align_mode,
    input  logic [2:0]   out_mode,
    input  logic         rld_pre_en,
    input  logic         rld_wr,
    input  logic [W-1:0] rld_wdata,
    input  logic         cmp_pre_en,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         upd_gen,
    input  logic         flag_clr,
    input  logic         irq_en,
    output logic [W-1:0] cnt_val,
    output logic         cnt_dir,
    output logic         upd_evt,
    output logic         ocref,
    output logic         cmp_flag,
    output logic         irq
);

    logic [W-1:0] rld_sh;
    logic [W-1:0] ccr_sh;
    logic         upd_now;

    pwm_ch_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .upd_gen (upd_gen),
        .align   (align_mode),
        .rld_sh  (rld_sh),
        .cnt     (cnt_val),
        .down    (cnt_dir),
        .upd_now (upd_now),
        .upd_evt (upd_evt)
    );

    pwm_ch_preload #(.W(W), .INIT(RLD_INIT)) u_rld (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_en  (rld_pre_en),
        .wr      (rld_wr),
        .wdata   (rld_wdata),
        .upd_now (upd_now),
        .active  (rld_sh)
    );

    pwm_ch_preload #(.W(W), .INIT(CMP_INIT)) u_ccr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_en  (cmp_pre_en),
        .wr      (cmp_wr),
        .wdata   (cmp_wdata),
        .upd_now (upd_now),
        .active  (ccr_sh)
    );

    pwm_ch_compare #(.W(W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .cnt      (cnt_val),
        .down     (cnt_dir),
        .ccr_sh   (ccr_sh),
        .align    (align_mode),
        .out_mode (out_mode),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .ocref    (ocref),
        .flag     (cmp_flag),
        .irq      (irq)
    );

endmodule

// File: rtl/pwm_cmp_channel_chk.sv
module pwm_cmp_channel_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic [1:0]   align_mode,
    input logic [2:0]   out_mode,
    input logic         cmp_pre_en,
    input logic         upd_gen,
    input logic         flag_clr,
    input logic         irq_en,
    input logic [W-1:0] cnt_val,
    input logic         cnt_dir,
    input logic         upd_evt,
    input logic         ocref,
    input logic         cmp_flag,
    input logic         irq,
    input logic [W-1:0] ccr_sh,
    input logic         upd_now
);

    a_r1_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 3'b100) |-> !ocref);

    a_r2_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 3'b101) |-> ocref);

    a_r3_pwm_a_below: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 3'b110 && cnt_val < ccr_sh) |-> !ocref);

    a_r3_pwm_b_below: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 3'b111 && cnt_val < ccr_sh) |-> ocref);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr) |=> cmp_flag);

    a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cmp_flag && irq_en));

    a_r6_edge_up: assert property (@(posedge clk) disable iff (!rst_n)
        (align_mode == 2'b00 && cnt_en && !upd_gen) |=> !cnt_dir);

    a_r9_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_pre_en && !upd_now) |=> $stable(ccr_sh));

    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        upd_gen |=> (cnt_val == '0 && !cnt_dir && upd_evt));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !upd_gen) |=> $stable(cnt_val));

endmodule

bind pwm_cmp_channel pwm_cmp_channel_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .align_mode (align_mode),
    .out_mode   (out_mode),
    .cmp_pre_en (cmp_pre_en),
    .upd_gen    (upd_gen),
    .flag_clr   (flag_clr),
    .irq_en     (irq_en),
    .cnt_val    (cnt_val),
    .cnt_dir    (cnt_dir),
    .upd_evt    (upd_evt),
    .ocref      (ocref),
    .cmp_flag   (cmp_flag),
    .irq        (irq),
    .ccr_sh     (ccr_sh),
    .upd_now    (upd_now)
);

// File: tb/pwm_cmp_channel_bench.sv
module pwm_cmp_channel_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic [1:0]   align_mode = 2'b00;
    logic [2:0]   out_mode = 3'b000;
    logic         rld_pre_en = 1'b0;
    logic         rld_wr = 1'b0;
    logic [W-1:0] rld_wdata = '0;
    logic         cmp_pre_en = 1'b0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         upd_gen = 1'b0;
    logic         flag_clr = 1'b0;
    logic         irq_en = 1'b0;
    logic [W-1:0] cnt_val;
    logic         cnt_dir;
    logic         upd_evt;
    logic         ocref;
    logic         cmp_flag;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_cmp_channel #(.W(W)) u_pwm_cmp_channel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .align_mode (align_mode),
        .out_mode   (out_mode),
        .rld_pre_en (rld_pre_en),
        .rld_wr     (rld_wr),
        .rld_wdata  (rld_wdata),
        .cmp_pre_en (cmp_pre_en),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .upd_gen    (upd_gen),
        .flag_clr   (flag_clr),
        .irq_en     (irq_en),
        .cnt_val    (cnt_val),
        .cnt_dir    (cnt_dir),
        .upd_evt    (upd_evt),
        .ocref      (ocref),
        .cmp_flag   (cmp_flag),
        .irq        (irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // upd_gen for one edge; returns at sample k = 0
    task automatic restart();
        upd_gen = 1'b1;
        step();
        upd_gen = 1'b0;
    endtask

    task automatic direct_write(input int rv, input int cv);
        rld_pre_en = 1'b0; cmp_pre_en = 1'b0;
        rld_wr = 1'b1; rld_wdata = W'(rv);
        cmp_wr = 1'b1; cmp_wdata = W'(cv);
        step();
        rld_wr = 1'b0; cmp_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // Reset state
        chk(cnt_val == 0, "R6 reset cnt", int'(cnt_val), 0);
        chk(cnt_dir == 0, "R7 reset dir", int'(cnt_dir), 0);
        chk(cmp_flag == 0, "R5 reset flag", int'(cmp_flag), 0);
        chk(irq == 0, "R5 reset irq", int'(irq), 0);
        chk(upd_evt == 0, "R6 reset upd_evt", int'(upd_evt), 0);
        chk(ocref == 0, "R1 mode 000 low", int'(ocref), 0);

        // Edge-aligned sweep, reload 5, compare 2, flag cleared every cycle
        direct_write(5, 2);
        align_mode = 2'b00; cnt_en = 1'b1; flag_clr = 1'b1; irq_en = 1'b1;
        restart();
        for (int k = 0; k < 18; k++) begin
            int c;
            int pc;
            c = k % 6;
            pc = (k + 5) % 6;
            chk(int'(cnt_val) == c, "R6 edge count", int'(cnt_val), c);
            chk(upd_evt == (c == 0), "R6 edge upd_evt", int'(upd_evt), int'(c == 0));
            chk(cnt_dir == 0, "R6 edge dir", int'(cnt_dir), 0);
            if (k > 0) begin
                chk(cmp_flag == (pc == 2), "R4 edge flag", int'(cmp_flag), int'(pc == 2));
                chk(irq == (pc == 2), "R5 irq follows flag", int'(irq), int'(pc == 2));
            end
            for (int m = 4; m < 8; m++) begin
                bit e;
                out_mode = 3'(m);
                #1;
                case (m)
                    4: e = 1'b0;
                    5: e = 1'b1;
                    6: e = (c > 2);
                    default: e = !(c > 2);
                endcase
                chk(ocref == e, m == 4 ? "R1 force low" : m == 5 ? "R2 force high" : "R3 pwm level",
                    int'(ocref), int'(e));
            end
            step();
        end

        // Forced-low flag behaviour, set-wins, sticky, irq gating
        out_mode = 3'b100; flag_clr = 1'b1;
        restart();                               // k0 cnt 0
        step();                                  // k1 cnt 1
        flag_clr = 1'b0;
        step();                                  // k2 cnt 2 (match)
        chk(cmp_flag == 0, "R4 no flag before match", int'(cmp_flag), 0);
        flag_clr = 1'b1;                         // clear together with set
        step();                                  // k3
        flag_clr = 1'b0;
        chk(cmp_flag == 1, "R5 set wins over clear (forced low, R4)", int'(cmp_flag), 1);
        chk(ocref == 0, "R1 forced low during match", int'(ocref), 0);
        step();                                  // k4
        chk(cmp_flag == 1, "R5 flag sticky", int'(cmp_flag), 1);
        irq_en = 1'b0; #1;
        chk(irq == 0, "R5 irq masked", int'(irq), 0);
        irq_en = 1'b1; #1;
        chk(irq == 1, "R5 irq enabled", int'(irq), 1);
        flag_clr = 1'b1;
        step();                                  // k5
        chk(cmp_flag == 0, "R5 flag cleared", int'(cmp_flag), 0);

        // Center-aligned sweeps, reload 4, compare 1
        direct_write(4, 1);
        out_mode = 3'b110; flag_clr = 1'b1;
        for (int a = 1; a < 4; a++) begin
            align_mode = 2'(a);
            restart();
            for (int k = 0; k < 24; k++) begin
                int p, c, pp, pcnt;
                bit dn, pdn, qual, eu;
                p = k % 8;
                c = (p <= 4) ? p : 8 - p;
                dn = (p > 4) || (p == 0 && k > 0);
                eu = (k == 0) || (p == 5) || (p == 1 && k > 1);
                chk(int'(cnt_val) == c, "R7 center count", int'(cnt_val), c);
                chk(cnt_dir == dn, "R7 center dir", int'(cnt_dir), int'(dn));
                chk(upd_evt == eu, "R7 center upd_evt", int'(upd_evt), int'(eu));
                chk(ocref == (c > 1), "R3 center pwm level", int'(ocref), int'(c > 1));
                if (k > 0) begin
                    pp = (k - 1) % 8;
                    pcnt = (pp <= 4) ? pp : 8 - pp;
                    pdn = (pp > 4) || (pp == 0 && k - 1 > 0);
                    qual = (a == 1) ? pdn : (a == 2) ? !pdn : 1'b1;
                    chk(cmp_flag == (pcnt == 1 && qual), "R8 center flag timing",
                        int'(cmp_flag), int'(pcnt == 1 && qual));
                end
                step();
            end
        end

        // Mid-period restart while counting down
        while (cnt_dir != 1'b1) step();
        restart();
        chk(cnt_val == 0 && cnt_dir == 0, "R11 restart from down slope",
            int'(cnt_val) + 100 * int'(cnt_dir), 0);
        chk(upd_evt == 1, "R11 restart upd_evt", int'(upd_evt), 1);

        // Preloaded writes, edge-aligned
        align_mode = 2'b00; flag_clr = 1'b0;
        rld_pre_en = 1'b1; cmp_pre_en = 1'b1;
        rld_wr = 1'b1; rld_wdata = 8'd5; cmp_wr = 1'b1; cmp_wdata = 8'd2;
        step();
        rld_wr = 1'b0; cmp_wr = 1'b0;
        restart();                               // k0, loads R=5 C=2
        step();                                  // k1
        rld_wr = 1'b1; rld_wdata = 8'd3; cmp_wr = 1'b1; cmp_wdata = 8'd4;
        step();                                  // k2
        rld_wr = 1'b0; cmp_wr = 1'b0;
        step();                                  // k3
        chk(cnt_val == 3 && ocref == 1, "R9 compare held until update",
            int'(ocref), 1);
        step(); step();                          // k5
        chk(cnt_val == 5, "R10 reload held until update", int'(cnt_val), 5);
        step();                                  // k6
        chk(cnt_val == 0 && upd_evt == 1, "R6 wrap at held reload", int'(cnt_val), 0);
        step(); step(); step();                  // k9
        chk(cnt_val == 3 && ocref == 0, "R9 compare applied after update",
            int'(ocref), 0);
        step();                                  // k10
        chk(cnt_val == 0, "R10 new reload applied after update", int'(cnt_val), 0);

        // Software update loads preload
        cmp_wr = 1'b1; cmp_wdata = 8'd0;
        step();
        cmp_wr = 1'b0;
        restart();                               // k0
        step();                                  // k1 cnt 1
        chk(ocref == 1, "R11 update strobe loads compare", int'(ocref), 1);

        // Compare without preload: takes effect next cycle
        restart();                               // k0
        cmp_pre_en = 1'b0; cmp_wr = 1'b1; cmp_wdata = 8'd3;
        step();                                  // k1
        cmp_wr = 1'b0;
        step();                                  // k2
        chk(cnt_val == 2 && ocref == 0, "R9 direct compare write", int'(ocref), 0);

        // Reload without preload: takes effect next cycle
        rld_wr = 1'b1; rld_wdata = 8'd2;
        step();                                  // k3 cnt 3 >= 2 wraps next
        rld_wr = 1'b0;
        step();
        chk(cnt_val == 0, "R10 direct reload write", int'(cnt_val), 0);

        // Counter hold
        step();
        begin
            logic [W-1:0] held;
            held = cnt_val;
            cnt_en = 1'b0; flag_clr = 1'b1;
            cmp_wr = 1'b1; cmp_wdata = held;
            step();
            flag_clr = 1'b0; cmp_wr = 1'b0;
            step(); step(); step();
            chk(cnt_val == held, "R12 counter holds", int'(cnt_val), int'(held));
            chk(cmp_flag == 0, "R12 no flag while stopped", int'(cmp_flag), 0);
            cnt_en = 1'b1;
            step();
            chk(cmp_flag == 1, "R4 flag on resume match", int'(cmp_flag), 1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule